// File: doc/BRIEF.md
# Auxiliary Memory Page Mapper

This block decides, for each 256-byte page of a 16-bit processor address space, where a read and where a write should go. The possible targets are main RAM, auxiliary RAM, the I/O switch page, the system ROM, and the peripheral-card ROM window. The read target and the write target are computed separately, so a program can fetch from one bank while it stores into the other.

The choice depends on eight mode flags that the block holds in registers. Software, or the surrounding switch decoder, sets or clears each flag one at a time through a small configuration port. A ninth flag enables the internal ROM over the $C8–$CF expansion window. A two-state machine owns this flag and changes it by watching bus accesses, not the configuration port:

- In state `C8_CARD`, the card owns the expansion window.
- The `ARM` transition moves the machine to `C8_INTERNAL`. It fires on an access to page $C3 while the slot-C3 flag is clear.
- The `DISARM` transition returns the machine to `C8_CARD`. It fires on an access to $CFFF.

Both page selects are purely combinational from the flags, the machine state and the upper address byte. A RAM controller can therefore steer the current access in the same cycle.

Top module: `aux_page_mapper`

## Requirements
- R1: Source codes are main=0, aux=1, io=2, system ROM=3, card ROM=4. With every flag clear and the machine in `C8_CARD`, the mapping is as follows. Pages $00–$BF read and write main. Page $C0 reads and writes io. Pages $C1–$FF write system ROM. Pages $C1–$FF read system ROM, except where R6 gives card ROM.
- R2: When the alternate-zero-page flag is set, pages $00 and $01 read and write aux. When it is clear, they read and write main.
- R3: On pages $02–$BF, when no override from R4 or R5 applies, the read source is aux exactly when aux-read is set. The write source is aux exactly when aux-write is set. The two flags act independently.
- R4: When the 80-column-store flag is set, pages $04–$07 read and write aux if display-page-2 is set, and main if it is clear. This holds regardless of aux-read and aux-write.
- R5: When 80-column-store and hires are both set, pages $20–$3F follow display-page-2 in the same way as R4. When hires is clear, R3 governs these pages.
- R6: When internal-Cx is clear, reads of pages $C1–$CF give card ROM, with two exceptions. Page $C3 reads system ROM when slot-C3 is clear. Pages $C8–$CF read system ROM while the machine is in `C8_INTERNAL`. When internal-Cx is set, all of $C1–$CF reads system ROM.
- R7: An access (acc_valid high) to any address in page $C3 while slot-C3 is clear takes the machine from `C8_CARD` to `C8_INTERNAL`, effective in the next cycle. With acc_valid low, or with slot-C3 set, the machine stays in `C8_CARD`.
- R8: An access to exactly $CFFF takes the machine from `C8_INTERNAL` to `C8_CARD`, effective in the next cycle. Other addresses in page $CF leave it in `C8_INTERNAL`.
- R9: wr_drop is high whenever acc_write is high and the write source is system ROM or card ROM. It is low otherwise.
- R10: The configuration port works as follows. When cfg_wr is high at a clock edge, flag cfg_sel takes the value cfg_val. The flag index encoding is: 0 alternate zero page, 1 aux read, 2 aux write, 3 80-column store, 4 display page 2, 5 hires, 6 internal Cx, 7 slot C3. Reset clears all flags and puts the machine in `C8_CARD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Flag update strobe |
| cfg_sel | input | 3 | Index of the flag to update |
| cfg_val | input | 1 | New value for the selected flag |
| acc_valid | input | 1 | A bus access occurs this cycle |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 16 | Access address |
| rd_src | output | 3 | Read source for the page of acc_addr |
| wr_src | output | 3 | Write source for the page of acc_addr |
| wr_drop | output | 1 | A write aimed at ROM, to be discarded |

## Verification
The assertions check the following on every cycle:
- the fixed mappings of the zero-page, I/O, bank-split, display-override and card-window rules against the live flags;
- that both transitions of the expansion-window machine occur one cycle after their triggering access;
- that the machine holds its state while no access occurs;
- that ROM-directed writes are flagged.

Some behaviours can only be shown by the bench's scenarios:
- that all 256 flag combinations map every page correctly, in both machine states;
- that near-miss addresses such as $CFFE and idle cycles on page $C3 leave the machine alone;
- that a flag update takes effect after exactly one edge.

// File: rtl/apm_pkg.sv
package apm_pkg;

    typedef enum logic [2:0] {
        SRC_MAIN    = 3'd0,
        SRC_AUX     = 3'd1,
        SRC_IO      = 3'd2,
        SRC_SYSROM  = 3'd3,
        SRC_CARDROM = 3'd4
    } src_e;

    typedef enum logic {
        C8_CARD     = 1'b0,
        C8_INTERNAL = 1'b1
    } c8_state_e;

    localparam int NUM_FLAGS = 8;
    localparam int FLAG_SEL_W = $clog2(NUM_FLAGS);

    // Bit 0 is the last member listed.
    typedef struct packed {
        logic slot_c3;
        logic int_cx;
        logic hires;
        logic page2;
        logic store80;
        logic aux_wr;
        logic aux_rd;
        logic alt_zp;
    } mode_t;

    localparam int PAGE_W = 8;
    localparam logic [PAGE_W-1:0] PG_STACK_END = 8'h01;
    localparam logic [PAGE_W-1:0] PG_TEXT_LO   = 8'h04;
    localparam logic [PAGE_W-1:0] PG_TEXT_HI   = 8'h07;
    localparam logic [PAGE_W-1:0] PG_HGR_LO    = 8'h20;
    localparam logic [PAGE_W-1:0] PG_HGR_HI    = 8'h3F;
    localparam logic [PAGE_W-1:0] PG_RAM_END   = 8'hBF;
    localparam logic [PAGE_W-1:0] PG_IO        = 8'hC0;
    localparam logic [PAGE_W-1:0] PG_SLOT3     = 8'hC3;
    localparam logic [PAGE_W-1:0] PG_EXP_LO    = 8'hC8;
    localparam logic [PAGE_W-1:0] PG_CX_END    = 8'hCF;

endpackage

// File: rtl/apm_mode_regs.sv
module apm_mode_regs
    import apm_pkg::*;
#(
    parameter int N = NUM_FLAGS,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_val,
    output logic [N-1:0]     flags_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (cfg_wr && cfg_sel == SEL_W'(i))
                flags_q[i] <= cfg_val;
        end
    end

endmodule

// File: rtl/apm_c8_ctrl.sv
module apm_c8_ctrl
    import apm_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int PAGE_LSB = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              slot_c3,
    output logic              c8_on
);

    localparam logic [ADDR_W-1:0] RELEASE_ADDR = {PG_CX_END, {PAGE_LSB{1'b1}}};

    c8_state_e state_q, state_d;
    logic      arm_hit, release_hit;

    assign arm_hit     = acc_valid && (acc_addr[ADDR_W-1 -: PAGE_W] == PG_SLOT3) && !slot_c3;
    assign release_hit = acc_valid && (acc_addr == RELEASE_ADDR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C8_CARD:     if (arm_hit)     state_d = C8_INTERNAL;
            C8_INTERNAL: if (release_hit) state_d = C8_CARD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C8_CARD;
        else        state_q <= state_d;
    end

    always_comb begin
        c8_on = 1'b0;
        unique case (state_q)
            C8_CARD:     c8_on = 1'b0;
            C8_INTERNAL: c8_on = 1'b1;
        endcase
    end

endmodule

// File: rtl/apm_page_decode.sv
module apm_page_decode
    import apm_pkg::*;
#(
    parameter bit WRITE_PORT = 1'b0
) (
    input  logic [PAGE_W-1:0] page,
    input  mode_t             mode,
    input  logic              c8_on,
    output src_e              src
);

    logic bank_aux;
    logic in_text, in_hgr;
    src_e disp_src;

    assign bank_aux = WRITE_PORT ? mode.aux_wr : mode.aux_rd;
    assign in_text  = (page >= PG_TEXT_LO) && (page <= PG_TEXT_HI);
    assign in_hgr   = (page >= PG_HGR_LO) && (page <= PG_HGR_HI);
    assign disp_src = mode.page2 ? SRC_AUX : SRC_MAIN;

    always_comb begin
        src = SRC_SYSROM;
        if (page <= PG_RAM_END) begin
            src = SRC_MAIN;
            if (page <= PG_STACK_END) begin
                if (mode.alt_zp) src = SRC_AUX;
            end else begin
                if (bank_aux) src = SRC_AUX;
                if (mode.store80 && in_text) src = disp_src;
                if (mode.store80 && mode.hires && in_hgr) src = disp_src;
            end
        end else if (page == PG_IO) begin
            src = SRC_IO;
        end else if (!WRITE_PORT && !mode.int_cx && page <= PG_CX_END) begin
            src = SRC_CARDROM;
            if (page == PG_SLOT3 && !mode.slot_c3) src = SRC_SYSROM;
            if (page >= PG_EXP_LO && c8_on) src = SRC_SYSROM;
        end
    end

endmodule

// File: rtl/aux_page_mapper.sv
module aux_page_mapper
    import apm_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int SEL_W = FLAG_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_val,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [2:0]        rd_src,
    output logic [2:0]        wr_src,
    output logic              wr_drop
);

    logic [NUM_FLAGS-1:0] flags_q;
    mode_t                mode_q;
    logic                 c8_on;
    src_e                 rd_e, wr_e;
    logic [PAGE_W-1:0]    page;

    assign mode_q = mode_t'(flags_q);
    assign page   = acc_addr[ADDR_W-1 -: PAGE_W];

    apm_mode_regs #(.N(NUM_FLAGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_sel (cfg_sel),
        .cfg_val (cfg_val),
        .flags_q (flags_q)
    );

    apm_c8_ctrl #(.ADDR_W(ADDR_W)) u_c8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .slot_c3   (mode_q.slot_c3),
        .c8_on     (c8_on)
    );

    apm_page_decode #(.WRITE_PORT(1'b0)) u_rd (
        .page  (page),
        .mode  (mode_q),
        .c8_on (c8_on),
        .src   (rd_e)
    );

    apm_page_decode #(.WRITE_PORT(1'b1)) u_wr (
        .page  (page),
        .mode  (mode_q),
        .c8_on (c8_on),
        .src   (wr_e)
    );

    assign rd_src  = rd_e;
    assign wr_src  = wr_e;
    assign wr_drop = acc_write && (wr_e == SRC_SYSROM || wr_e == SRC_CARDROM);

endmodule

// File: rtl/apm_checker.sv
module apm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [15:0] acc_addr,
    input logic [2:0]  rd_src,
    input logic [2:0]  wr_src,
    input logic        wr_drop,
    input logic [7:0]  flags,
    input logic        c8_on
);

    logic [7:0] pg;
    assign pg = acc_addr[15:8];

    p_io_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pg == 8'hC0 |-> rd_src == 3'd2 && wr_src == 3'd2);

    p_zp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && pg <= 8'h01 |-> rd_src == 3'd1 && wr_src == 3'd1);

    p_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[3] && pg >= 8'h02 && pg <= 8'hBF |->
            rd_src == {2'b00, flags[1]} && wr_src == {2'b00, flags[2]});

    p_text_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] && pg >= 8'h04 && pg <= 8'h07 |->
            rd_src == {2'b00, flags[4]} && wr_src == {2'b00, flags[4]});

    p_hgr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] && flags[5] && pg >= 8'h20 && pg <= 8'h3F |->
            rd_src == {2'b00, flags[4]} && wr_src == {2'b00, flags[4]});

    p_card_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[6] && pg >= 8'hC1 && pg <= 8'hCF && !(pg == 8'hC3 && !flags[7])
            && !(pg >= 8'hC8 && c8_on) |-> rd_src == 3'd4);

    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && pg == 8'hC3 && !flags[7] |=> c8_on);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(c8_on));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_addr == 16'hCFFF |=> !c8_on);

    p_rom_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write && pg >= 8'hC1 |-> wr_drop);

    p_ram_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pg <= 8'hC0 |-> !wr_drop);

endmodule

bind aux_page_mapper apm_checker u_apm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .rd_src    (rd_src),
    .wr_src    (wr_src),
    .wr_drop   (wr_drop),
    .flags     (flags_q),
    .c8_on     (c8_on)
);

// File: tb/aux_page_mapper_bench.sv
`timescale 1ns/1ps
module aux_page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_val = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [2:0]  rd_src, wr_src;
    logic        wr_drop;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aux_page_mapper u_aux_page_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_val   (cfg_val),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .rd_src    (rd_src),
        .wr_src    (wr_src),
        .wr_drop   (wr_drop)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s addr=%h act=%0d exp=%0d", req, acc_addr, act, exp);
        end
    endtask

    // Expected source: 0 main, 1 aux, 2 io, 3 system ROM, 4 card ROM.
    function automatic int model(input int pg, input logic [7:0] f, input bit c8, input bit w);
        if (pg >= 'hC1) begin
            if (w || f[6] || pg > 'hCF) return 3;
            if (pg == 'hC3) return f[7] ? 4 : 3;
            if (pg >= 'hC8) return c8 ? 3 : 4;
            return 4;
        end
        if (pg == 'hC0) return 2;
        if (pg < 2) return int'(f[0]);
        if (f[3] && ((pg >= 4 && pg < 8) || (f[5] && pg >= 'h20 && pg < 'h40)))
            return int'(f[4]);
        return w ? int'(f[2]) : int'(f[1]);
    endfunction

    function automatic string tag(input int pg);
        if (pg < 2) return "R2";
        if (pg >= 4 && pg < 8) return "R4";
        if (pg >= 'h20 && pg < 'h40) return "R5";
        if (pg < 'hC0) return "R3";
        if (pg == 'hC0) return "R1";
        return "R6";
    endfunction

    task automatic set_flag(input int idx, input bit v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'(idx); cfg_val = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic sweep(input logic [7:0] f, input bit c8);
        for (int p = 0; p < 256; p++) begin
            acc_addr  = {p[7:0], 8'h5A};
            acc_write = p[0];
            #1;
            chk(tag(p), int'(rd_src), model(p, f, c8, 1'b0));
            chk(tag(p), int'(wr_src), model(p, f, c8, 1'b1));
            chk("R9", int'(wr_drop), int'(p[0] && model(p, f, c8, 1'b1) >= 3));
        end
        acc_write = 1'b0;
    endtask

    task automatic rd_at(input string req, input logic [15:0] a, input int exp);
        acc_addr = a;
        #1;
        chk(req, int'(rd_src), exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd_at("R10", 16'h0010, 0);
        rd_at("R10", 16'hC800, 4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset defaults, R1 default map
        sweep(8'h00, 1'b0);

        // R10: flag update visible after exactly one edge
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'd1; cfg_val = 1'b1;
        acc_addr = 16'h1000;
        #1 chk("R10", int'(rd_src), 0);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1 chk("R10", int'(rd_src), 1);
        set_flag(1, 1'b0);

        // R7: idle cycles on page C3 do not arm
        @(negedge clk);
        acc_addr = 16'hC310;
        repeat (3) @(negedge clk);
        rd_at("R7", 16'hC900, 4);
        // R7: slot-C3 set blocks arming
        set_flag(7, 1'b1);
        access(16'hC3FF);
        rd_at("R7", 16'hC900, 4);
        set_flag(7, 1'b0);
        // R7: arming, visible the cycle after the access
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 16'hC344;
        #1 chk("R7", int'(rd_src), 3);
        acc_addr = 16'hC344;
        @(negedge clk);
        acc_valid = 1'b0;
        rd_at("R7", 16'hCF00, 3);
        rd_at("R6", 16'hC700, 4);
        // R8: near miss keeps it armed
        access(16'hCFFE);
        rd_at("R8", 16'hC800, 3);
        access(16'hCFFF);
        rd_at("R8", 16'hC800, 4);
        // R8: release when already in card state is harmless
        access(16'hCFFF);
        rd_at("R8", 16'hCA00, 4);

        // Full sweep: every flag combination, both machine states.
        for (int m = 0; m < 256; m++) begin
            for (int b = 0; b < 8; b++) set_flag(b, m[b]);
            sweep(m[7:0], 1'b0);
            set_flag(7, 1'b0);
            access(16'hC300);
            set_flag(7, m[7]);
            sweep(m[7:0], 1'b1);
            access(16'hCFFF);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule